// File: doc/BRIEF.md
# Timer Compare Output Stage

This block turns the compare-match events of a timer into one output bit. It keeps an internal compare state bit. On every compare-match pulse it sets, clears or toggles that bit, or leaves it alone, as a 2-bit action field selects. The same field decides what drives the physical pin: the compare state bit, or the ordinary port data bit. Pin direction always follows the port direction bit.

The action field is double-buffered. The value presented on `mode_i` acts as the pending copy. It is copied into an internal active copy on each compare-match pulse, and the pin source is decided by the active copy. A write to the field therefore changes the pin source at the first compare match after the write. That same match already uses the new action.

A force strobe applies the pending action at once, without waiting for a match. The strobe only works while the timer is outside its PWM modes. With a force, software can preset the compare state bit while the pin is still an input or still shows port data.

Top module: `cmo_unit`

## Requirements
- R1: After reset the compare state bit is 0 and the active action field is 00, so the pin shows the port data bit.
- R2: With field value 00, neither a compare match nor a force changes the compare state bit.
- R3: On a compare-match pulse, the field value present in that cycle acts on the compare state bit at that clock edge. The codes are 01 toggle, 10 clear and 11 set.
- R4: The active field is reloaded from `mode_i` only on a compare-match pulse. While the active field is not 00 the pin carries the compare state bit; while it is 00 the pin carries the port data bit.
- R5: The pin output-enable always equals the port direction bit.
- R6: When the PWM indicator is low, a force strobe applies the action of the present `mode_i` at the next clock edge, and it does not reload the active field.
- R7: While the PWM indicator is high, a force strobe has no effect on the compare state bit.
- R8: A compare match and a force in the same cycle apply the action only once. A toggle flips the bit a single time.
- R9: The compare state bit can be preset by force while the pin output-enable is low and the active field is 00, and the pin keeps showing port data until a match loads a non-zero active field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| match_i | input | 1 | Compare-match pulse from the timer |
| mode_i | input | 2 | Pending action field (00 none, 01 toggle, 10 clear, 11 set) |
| force_i | input | 1 | Force strobe, applies the action immediately |
| pwm_i | input | 1 | High while the timer runs a PWM mode |
| port_data_i | input | 1 | Ordinary port data bit |
| port_dir_i | input | 1 | Port direction bit, 1 = output |
| oc_q_o | output | 1 | Internal compare state bit |
| pin_o | output | 1 | Value presented to the pin |
| pin_oe_o | output | 1 | Pin output-enable |

## Verification
The checker watches every cycle for these rules:
- each match action (set, clear, toggle) appears one edge after the match;
- a 00 field freezes the state bit;
- a force under PWM freezes the state bit.

The double-buffering only shows up across several cycles. The bench scenarios cover that:
- a field written without a match leaves the pin source unchanged;
- a force does not reload the active copy;
- a coincident match and force toggle once;
- the state bit is preset while the pin is still an input.

Random traffic compares state, pin and enable against a reference model on every cycle.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
   localparam int unsigned CMO_MODE_W = 2;

   typedef enum logic [CMO_MODE_W-1:0] {
      CMO_KEEP   = 2'b00,
      CMO_TOGGLE = 2'b01,
      CMO_CLEAR  = 2'b10,
      CMO_SET    = 2'b11
   } cmo_act_e;

   function automatic logic cmo_apply(input cmo_act_e act, input logic cur);
      case (act)
         CMO_TOGGLE: cmo_apply = ~cur;
         CMO_CLEAR:  cmo_apply = 1'b0;
         CMO_SET:    cmo_apply = 1'b1;
         default:    cmo_apply = cur;
      endcase
   endfunction
endpackage

// File: rtl/cmo_mode_buf.sv
module cmo_mode_buf
   import cmo_pkg::*;
#(
   parameter int unsigned MODE_W = CMO_MODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [MODE_W-1:0] pend_i,
   output logic [MODE_W-1:0] act_o
);
   localparam logic [MODE_W-1:0] IDLE = '0;

   logic [MODE_W-1:0] act_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      act_q <= IDLE;
      else if (load_i) act_q <= pend_i;
   end

   assign act_o = act_q;
endmodule

// File: rtl/cmo_state.sv
module cmo_state
   import cmo_pkg::*;
#(
   parameter int unsigned MODE_W = CMO_MODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              match_i,
   input  logic              force_i,
   input  logic              pwm_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic              oc_o
);
   logic oc_q;
   logic event_w;
   logic oc_nxt;

   assign event_w = match_i | (force_i & ~pwm_i);

   always_comb begin
      oc_nxt = oc_q;
      if (event_w) oc_nxt = cmo_apply(cmo_act_e'(mode_i), oc_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) oc_q <= 1'b0;
      else        oc_q <= oc_nxt;
   end

   assign oc_o = oc_q;
endmodule

// File: rtl/cmo_pin_sel.sv
module cmo_pin_sel #(
   parameter int unsigned MODE_W = 2
) (
   input  logic [MODE_W-1:0] act_i,
   input  logic              oc_i,
   input  logic              port_data_i,
   input  logic              port_dir_i,
   output logic              pin_o,
   output logic              pin_oe_o
);
   logic takeover;

   assign takeover = |act_i;
   assign pin_o    = takeover ? oc_i : port_data_i;
   assign pin_oe_o = port_dir_i;
endmodule

// File: rtl/cmo_unit.sv
module cmo_unit
   import cmo_pkg::*;
#(
   parameter int unsigned MODE_W = CMO_MODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              match_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              force_i,
   input  logic              pwm_i,
   input  logic              port_data_i,
   input  logic              port_dir_i,
   output logic              oc_q_o,
   output logic              pin_o,
   output logic              pin_oe_o
);
   generate
      if (MODE_W != CMO_MODE_W) begin : g_bad_width
         $error("cmo_unit: MODE_W must equal the package action width");
      end
   endgenerate

   logic [MODE_W-1:0] act_w;
   logic              oc_w;

   cmo_mode_buf #(.MODE_W(MODE_W)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (match_i),
      .pend_i (mode_i),
      .act_o  (act_w)
   );

   cmo_state #(.MODE_W(MODE_W)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .match_i (match_i),
      .force_i (force_i),
      .pwm_i   (pwm_i),
      .mode_i  (mode_i),
      .oc_o    (oc_w)
   );

   cmo_pin_sel #(.MODE_W(MODE_W)) u_pin (
      .act_i       (act_w),
      .oc_i        (oc_w),
      .port_data_i (port_data_i),
      .port_dir_i  (port_dir_i),
      .pin_o       (pin_o),
      .pin_oe_o    (pin_oe_o)
   );

   assign oc_q_o = oc_w;
endmodule

// File: rtl/cmo_unit_chk.sv
module cmo_unit_chk #(
   parameter int unsigned MODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              match_i,
   input logic [MODE_W-1:0] mode_i,
   input logic              force_i,
   input logic              pwm_i,
   input logic              oc_q_o
);
   assert_match_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (match_i && mode_i == 2'b11) |=> oc_q_o);

   assert_match_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (match_i && mode_i == 2'b10) |=> !oc_q_o);

   assert_match_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (match_i && mode_i == 2'b01) |=> (oc_q_o != $past(oc_q_o)));

   assert_keep_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b00) |=> $stable(oc_q_o));

   assert_pwm_force_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!match_i && pwm_i) |=> $stable(oc_q_o));
endmodule

bind cmo_unit cmo_unit_chk #(.MODE_W(MODE_W)) u_cmo_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .match_i (match_i),
   .mode_i  (mode_i),
   .force_i (force_i),
   .pwm_i   (pwm_i),
   .oc_q_o  (oc_q_o)
);

// File: tb/test_cmo_unit.sv
module test_cmo_unit;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       match_i, force_i, pwm_i, port_data_i, port_dir_i;
   logic [1:0] mode_i;
   logic       oc_q_o, pin_o, pin_oe_o;

   int checks = 0;
   int errors = 0;
   logic       m_oc;
   logic [1:0] m_act;

   always #5 clk = ~clk;

   cmo_unit i_cmo_unit (
      .clk(clk), .rst_n(rst_n), .match_i(match_i), .mode_i(mode_i),
      .force_i(force_i), .pwm_i(pwm_i), .port_data_i(port_data_i),
      .port_dir_i(port_dir_i), .oc_q_o(oc_q_o), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
   );

   function automatic logic f_act(input logic [1:0] code, input logic cur);
      case (code)
         2'b01:   return ~cur;
         2'b10:   return 1'b0;
         2'b11:   return 1'b1;
         default: return cur;
      endcase
   endfunction

   function automatic logic f_pin(input logic [1:0] act, input logic oc, input logic pd);
      return (act != 2'b00) ? oc : pd;
   endfunction

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic f, input logic p, input logic [1:0] md,
                       input logic pd, input logic dir, input string req);
      @(negedge clk);
      match_i = m; force_i = f; pwm_i = p; mode_i = md; port_data_i = pd; port_dir_i = dir;
      @(posedge clk);
      if (m | (f & ~p)) m_oc = f_act(md, m_oc);
      if (m) m_act = md;
      #1;
      chk(req, "oc", oc_q_o, m_oc);
      chk(req, "pin", pin_o, f_pin(m_act, m_oc, pd));
      chk("R5", "oe", pin_oe_o, dir);
   endtask

   initial begin
      #1500000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; match_i = 0; force_i = 0; pwm_i = 0; mode_i = 2'b00;
      port_data_i = 1'b1; port_dir_i = 1'b0;
      m_oc = 1'b0; m_act = 2'b00;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "oc after reset", oc_q_o, 1'b0);
      chk("R1", "pin shows port data", pin_o, 1'b1);
      @(negedge clk); rst_n = 1'b1;

      // R2: match with code 00 leaves state
      step(1, 0, 0, 2'b00, 0, 1, "R2");
      // R3: set, toggle, toggle, clear
      step(1, 0, 0, 2'b11, 0, 1, "R3");
      chk("R3", "set by match", oc_q_o, 1'b1);
      step(1, 0, 0, 2'b01, 0, 1, "R3");
      chk("R3", "toggle to 0", oc_q_o, 1'b0);
      step(1, 0, 0, 2'b01, 0, 1, "R3");
      step(1, 0, 0, 2'b10, 1, 1, "R3");
      chk("R3", "clear by match", oc_q_o, 1'b0);
      // R4: field change without match keeps pin source (active = 10 -> oc = 0)
      step(0, 0, 0, 2'b00, 1, 1, "R4");
      chk("R4", "pin still from oc", pin_o, 1'b0);
      step(1, 0, 0, 2'b00, 1, 1, "R4");
      chk("R4", "pin back to port data", pin_o, 1'b1);
      // R6: force sets without loading active field
      step(0, 1, 0, 2'b11, 0, 1, "R6");
      chk("R6", "force set", oc_q_o, 1'b1);
      chk("R6", "active unchanged, pin port data", pin_o, 1'b0);
      // R7: force in PWM ignored
      step(0, 1, 1, 2'b10, 0, 1, "R7");
      chk("R7", "force ignored under pwm", oc_q_o, 1'b1);
      // R8: coincident match and force toggle once
      step(1, 1, 0, 2'b01, 0, 1, "R8");
      chk("R8", "single toggle", oc_q_o, 1'b0);
      // R9: preset while input, then enable via match
      step(1, 0, 0, 2'b00, 0, 0, "R9");
      step(0, 1, 0, 2'b11, 0, 0, "R9");
      chk("R9", "preset while oe low", oc_q_o, 1'b1);
      chk("R9", "pin still port data", pin_o, 1'b0);
      chk("R9", "oe low", pin_oe_o, 1'b0);
      step(1, 0, 0, 2'b11, 0, 1, "R9");
      chk("R9", "pin from preset bit", pin_o, 1'b1);

      // random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 3) == 0,
              2'($urandom), 1'($urandom), 1'($urandom), "R3/R4/R6/R7 random");
      end

      // reset in mid-run
      @(negedge clk); rst_n = 1'b0; port_data_i = 1'b0;
      @(posedge clk); #1;
      m_oc = 1'b0; m_act = 2'b00;
      chk("R1", "oc after second reset", oc_q_o, 1'b0);
      chk("R1", "pin port data after second reset", pin_o, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule